// File: doc/BRIEF.md
# Condition Flag and Conditional Branch Unit

This block holds the processor's three sign flags (negative, zero, strictly positive) and decides conditional branches. Every time a general register is written, the execution stage presents the written 16-bit value on a one-cycle write strobe. The unit classifies that value and keeps exactly one flag set. The flags always describe the most recent register write.

Branch requests arrive on a valid/ready stream. Each request carries the instruction word and the program counter, which the fetch stage has already incremented past the branch. The unit tests the instruction's flag mask against the current flags. A taken branch produces the incremented PC plus the sign-extended 9-bit offset. A branch that is not taken, and any instruction that is not a branch, yields the incremented PC unchanged.

The result leaves on a registered valid/ready stream. Back-pressure works as follows:
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty or is being drained in that same cycle.
- While `res_valid` is high and `res_ready` is low, the result holds steady and no new request is taken.

The write strobe has no back-pressure and is always absorbed.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset the flag state is zero-only (n=0, z=1, p=0) and `res_valid` is low.
- R2: Exactly one of the three flags is set in every cycle.
- R3: A write strobe with a value whose bit 15 is set makes N the flag. A value of zero makes Z the flag. Any other value makes P the flag. Branches accepted from the following cycle on see the new flag.
- R4: When a write strobe and an accepted branch fall in the same cycle, the branch is judged against the flags from before that write.
- R5: An instruction is a branch when bits [15:12] are 0000. Bit 11 selects n, bit 10 selects z and bit 9 selects p. The branch is taken when any selected flag is set.
- R6: A taken branch outputs `res_pc` = incremented PC + sign-extended bits [8:0], modulo 2^16. This reaches +255 and -256 words from the incremented PC.
- R7: A branch that is not taken outputs `res_taken`=0 and `res_pc` equal to the incremented PC. A mask of 000 is never taken.
- R8: A request whose bits [15:12] are not 0000 outputs `res_taken`=0 and `res_pc` equal to the incremented PC, whatever the flags are.
- R9: An accepted request shows its result with `res_valid`=1 after exactly one clock edge. While `res_ready` is low, the result stays stable and `req_ready` is low.
- R10: A mask of 111 is taken whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A general register is written this cycle |
| wr_data | input | 16 | Value written to the register |
| req_valid | input | 1 | Branch request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_instr | input | 16 | Instruction word |
| req_pc | input | 16 | Program counter already incremented past the instruction |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_pc | output | 16 | Next program counter |
| res_taken | output | 1 | Branch taken |

## Verification
A flag update and a branch decision can fall on the same clock edge. The bench raises the write strobe and an accepted branch request together, choosing the written value so that its sign differs from the current flag. The result must follow the old flag. A second branch right after must follow the new one. Holding back `res_ready` while a second request waits checks that the decision, once taken, is frozen and is not re-evaluated against later flags.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_flags_t;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] BR_OPCODE = '0;
  localparam cc_flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output cc_flags_t         flags
);
  cc_flags_t next_flags;

  always_comb begin
    next_flags.n = wr_data[DATA_W-1];
    next_flags.z = (wr_data == '0);
    next_flags.p = !wr_data[DATA_W-1] && (wr_data != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flags <= FLAGS_RESET;
    else if (wr_valid) flags <= next_flags;
  end
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
  import cc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  cc_flags_t         flags,
  output logic              taken,
  output logic [DATA_W-1:0] next_pc
);
  localparam int EXT_W = DATA_W - OFF_W;

  logic              is_branch;
  logic [2:0]        mask;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] target;

  assign is_branch = (instr[DATA_W-1 -: OPC_W] == BR_OPCODE);
  assign mask      = instr[OFF_W+2 : OFF_W];

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0]};
    end else begin : g_noext
      assign offset = instr[DATA_W-1:0];
    end
  endgenerate

  assign target  = pc_inc + offset;
  assign taken   = is_branch && |(mask & {flags.n, flags.z, flags.p});
  assign next_pc = taken ? target : pc_inc;
endmodule

// File: rtl/cc_result_stage.sv
module cc_result_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_pc,
  input  logic              in_taken,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_pc,
  output logic              out_taken
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_taken <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pc    <= in_pc;
        out_taken <= in_taken;
      end
    end
  end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_instr,
  input  logic [DATA_W-1:0] req_pc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_pc,
  output logic              res_taken
);
  cc_flags_t         flags_q;
  logic              eval_taken;
  logic [DATA_W-1:0] eval_pc;

  cc_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .flags(flags_q)
  );

  cc_branch_eval #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_eval (
    .instr(req_instr), .pc_inc(req_pc), .flags(flags_q),
    .taken(eval_taken), .next_pc(eval_pc)
  );

  cc_result_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_pc(eval_pc), .in_taken(eval_taken),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_pc(res_pc), .out_taken(res_taken)
  );
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DATA_W-1:0] req_instr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_pc,
  input logic              res_taken,
  input logic [2:0]        flags
);
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  a_r3_flag_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> flags == ($past(wr_data) == '0 ? 3'b010 :
                           ($past(wr_data[DATA_W-1]) ? 3'b100 : 3'b001)));

  a_r9_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_pc) && $stable(res_taken));

  a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);

  a_r7_empty_mask_never: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_instr[15:9] == 7'd0) |=> !res_taken);

  a_r10_full_mask_always: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_instr[15:9] == 7'b0000111) |=> res_taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
  .req_valid(req_valid), .req_ready(req_ready), .req_instr(req_instr),
  .res_valid(res_valid), .res_ready(res_ready), .res_pc(res_pc),
  .res_taken(res_taken), .flags(flags_q)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_instr = '0;
  logic [15:0] req_pc = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_pc;
  logic        res_taken;

  int checks = 0;
  int fails  = 0;
  logic [2:0] model_flags;   // {n,z,p}

  always #2 clk = ~clk;

  cc_branch_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] classify(input logic [15:0] v);
    if (v == 16'd0) return 3'b010;
    if (v[15])      return 3'b100;
    return 3'b001;
  endfunction

  function automatic logic exp_taken(input logic [15:0] ins, input logic [2:0] f);
    return (ins[15:12] == 4'd0) && ((ins[11:9] & f) != 3'd0);
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] ins, input logic [15:0] pc, input logic [2:0] f);
    if (exp_taken(ins, f)) return pc + {{7{ins[8]}}, ins[8:0]};
    return pc;
  endfunction

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = v;
    @(negedge clk);
    wr_valid = 1'b0;
    model_flags = classify(v);
  endtask

  task automatic branch(input string req, input logic [15:0] ins, input logic [15:0] pc);
    @(negedge clk);
    req_valid = 1'b1; req_instr = ins; req_pc = pc; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " taken"}, res_taken, exp_taken(ins, model_flags));
    chk({req, " pc"}, res_pc, exp_pc(ins, pc, model_flags));
  endtask

  task automatic t_reset;
    chk("R1 flags via mask z", 32'(u0.res_valid), 0);
    branch("R1 z-only after reset", 16'h0400 | 16'h0005, 16'h3000);
    chk("R1 z taken", res_taken, 1);
    branch("R1 n not set", 16'h0800 | 16'h0005, 16'h3000);
    chk("R1 n not taken", res_taken, 0);
  endtask

  task automatic t_flags;
    write_reg(16'h8000);
    branch("R3 negative n", 16'h0810, 16'h1000);
    branch("R3 negative p-mask R7", 16'h0210, 16'h1000);
    write_reg(16'h0001);
    branch("R3 positive p", 16'h0210, 16'h1000);
    branch("R5 nz mask on p", 16'h0C10, 16'h1000);
    write_reg(16'h0000);
    branch("R3 zero z", 16'h0410, 16'h1000);
    write_reg(16'h7FFF);
    branch("R5 zp mask on p", 16'h0610, 16'h1000);
  endtask

  task automatic t_offsets;
    write_reg(16'h0042);
    branch("R6 max forward", 16'h02FF, 16'h4000);
    chk("R6 +255", res_pc, 16'h40FF);
    branch("R6 max backward", 16'h0300, 16'h4000);
    chk("R6 -256", res_pc, 16'h3F00);
    branch("R6 wrap", 16'h0220, 16'hFFF0);
    chk("R6 wrap value", res_pc, 16'h0010);
  endtask

  task automatic t_masks;
    branch("R7 mask 000", 16'h0055, 16'h2000);
    chk("R7 mask 000 pc", res_pc, 16'h2000);
    write_reg(16'hFFFF);
    branch("R10 mask 111 n", 16'h0E07, 16'h2000);
    write_reg(16'h0000);
    branch("R10 mask 111 z", 16'h0E07, 16'h2000);
    chk("R10 taken", res_taken, 1);
  endtask

  task automatic t_nonbranch;
    branch("R8 opcode 0001", 16'h1E07, 16'h2100);
    chk("R8 not taken", res_taken, 0);
    branch("R8 opcode 1111", 16'hFE07, 16'h2100);
    chk("R8 pc", res_pc, 16'h2100);
  endtask

  task automatic t_same_cycle;
    write_reg(16'h0005);  // p
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 16'hF000;
    req_valid = 1'b1; req_instr = 16'h0203; req_pc = 16'h5000;
    @(negedge clk);
    wr_valid = 1'b0; req_valid = 1'b0;
    chk("R4 old flag used taken", res_taken, 1);
    chk("R4 old flag used pc", res_pc, 16'h5003);
    model_flags = 3'b100;
    branch("R4 new flag next", 16'h0203, 16'h5000);
    chk("R4 p now clear", res_taken, 0);
  endtask

  task automatic t_backpressure;
    write_reg(16'h0003);  // p
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1; req_instr = 16'h0204; req_pc = 16'h6000;
    @(negedge clk);
    chk("R9 first valid", res_valid, 1);
    chk("R9 ready low", req_ready, 0);
    req_instr = 16'h0808; req_pc = 16'h7000;   // n-mask, waits
    wr_valid = 1'b1; wr_data = 16'h8001;         // flag becomes n
    @(negedge clk);
    wr_valid = 1'b0; model_flags = 3'b100;
    @(negedge clk);
    chk("R9 held pc", res_pc, 16'h6004);
    chk("R9 held taken", res_taken, 1);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second valid", res_valid, 1);
    chk("R9 second pc", res_pc, 16'h7008);
    chk("R9 second taken", res_taken, 1);
    @(negedge clk);
    chk("R9 drained", res_valid, 0);
  endtask

  initial begin
    model_flags = 3'b010;
    repeat (3) @(negedge clk);
    chk("R1 res_valid low", res_valid, 0);
    rst_n = 1'b1;
    t_reset();
    t_flags();
    t_offsets();
    t_masks();
    t_nonbranch();
    t_same_cycle();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule